// File: doc/BRIEF.md
# Delayed-Start Wrapping Counter

This block is an up-counter that a single start level controls. When start goes from low to high, the block latches a terminal value from its input and forces the count to zero. It then waits a fixed number of clock cycles (two by default) before counting begins. While start stays high, the count advances by one per cycle. When the next value would reach the latched terminal value, the count returns to zero instead.

Every return to zero inverts a level-type overflow flag. A consumer detects a wrap by comparing the flag with its last seen level, so no pulse can be missed. When start drops, the count and the flag freeze. A later rising edge of start begins a fresh run, with a new latched terminal value and a new startup wait. The terminal-value input is ignored at all times except on the rising edge of start.

Top module: `ctr_delayed_wrap`

## Requirements
- R1: While the synchronous reset is high, and on the first cycle after it is released, count_o is 0 and ovf_o is 0.
- R2: The clock edge that sees start_i high after a cycle with start_i low sets count_o to 0 and latches limit_i as the terminal value.
- R3: For the DELAY_CYC clock edges (default 2) that follow a rising edge of start, count_o stays 0 while start_i stays high.
- R4: On every later edge with start_i high, count_o becomes count_o+1 when count_o+1 is less than the terminal value, and 0 otherwise. count_o is therefore never equal to or above a terminal value of 2 or more.
- R5: ovf_o inverts on exactly those running edges where the count wraps to 0, and it holds its level on all other edges.
- R6: With a terminal value of 5 and start held high, the first ovf_o inversion happens on the 7th edge after the edge that detected the rise. Later inversions come every 5 edges.
- R7: Changes on limit_i during a run have no effect on the counting sequence.
- R8: While start_i is low, count_o and ovf_o keep their values.
- R9: A rising edge of start after a low period starts a new run from 0. It uses the newly latched terminal value and applies the full startup wait again.
- R10: A terminal value of 0 keeps count_o at 0 with no inversion of ovf_o. A terminal value of 1 keeps count_o at 0 and inverts ovf_o on every running edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_i | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Run control; the rising edge arms a run, a low level freezes it |
| limit_i | input | CNT_W | Terminal value, latched on the rising edge of start |
| count_o | output | CNT_W | Present count |
| ovf_o | output | 1 | Overflow flag; its level inverts on each wrap |

## Verification
Two pairs of events can fall on the same edge. A wrap to zero and the toggle of the flag always coincide. The end of a run (start dropping) can also land on the edge where a wrap would have happened, and in that case the freeze must win. The bench lets start fall exactly where the reference model predicts a wrap. It also runs with a terminal value of 1, where every running edge both wraps and toggles. A per-edge scoreboard compares the count and the flag against a model built from the requirements.

// File: rtl/ctr_pkg.sv
package ctr_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_WAIT = 2'd1,
        PH_RUN  = 2'd2
    } phase_e;

    function automatic int unsigned dly_width(input int unsigned cycles);
        return (cycles < 1) ? 1 : $clog2(cycles + 1);
    endfunction

endpackage

// File: rtl/ctr_edge_detect.sv
module ctr_edge_detect (
    input  logic clk_i,
    input  logic rst_i,
    input  logic start_i,
    output logic rise_o
);

    logic start_d, start_q;

    always_comb begin
        start_d = start_i;
        rise_o  = start_i & ~start_q;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) start_q <= 1'b0;
        else       start_q <= start_d;
    end

endmodule

// File: rtl/ctr_start_delay.sv
module ctr_start_delay
    import ctr_pkg::*;
#(
    parameter int unsigned DELAY_CYC = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic start_i,
    input  logic rise_i,
    output logic step_o
);

    localparam int unsigned DLY_W = dly_width(DELAY_CYC);

    typedef struct packed {
        phase_e           ph;
        logic [DLY_W-1:0] dly;
    } dly_state_t;

    dly_state_t st_d, st_q;

    generate
        if (DELAY_CYC == 0) begin : g_nowait
            always_comb begin
                st_d = st_q;
                if (rise_i) begin
                    st_d.ph  = PH_RUN;
                    st_d.dly = '0;
                end else if (!start_i) begin
                    st_d.ph  = PH_IDLE;
                    st_d.dly = '0;
                end
            end
        end else begin : g_wait
            always_comb begin
                st_d = st_q;
                if (rise_i) begin
                    st_d.ph  = PH_WAIT;
                    st_d.dly = DLY_W'(DELAY_CYC);
                end else if (!start_i) begin
                    st_d.ph  = PH_IDLE;
                    st_d.dly = '0;
                end else if (st_q.ph == PH_WAIT) begin
                    if (st_q.dly == DLY_W'(1)) begin
                        st_d.ph  = PH_RUN;
                        st_d.dly = '0;
                    end else begin
                        st_d.dly = st_q.dly - DLY_W'(1);
                    end
                end
            end
        end
    endgenerate

    always_comb step_o = (st_q.ph == PH_RUN) && start_i && !rise_i;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q.ph  <= PH_IDLE;
            st_q.dly <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/ctr_wrap_core.sv
module ctr_wrap_core #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             rise_i,
    input  logic             step_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic [CNT_W-1:0] count_o,
    output logic [CNT_W-1:0] lim_o,
    output logic             ovf_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] lim;
        logic             ovf;
    } core_state_t;

    core_state_t st_d, st_q;
    logic [CNT_W:0] inc_w;

    always_comb begin
        st_d  = st_q;
        inc_w = {1'b0, st_q.cnt} + {{CNT_W{1'b0}}, 1'b1};
        if (rise_i) begin
            st_d.cnt = '0;
            st_d.lim = limit_i;
        end else if (step_i) begin
            if (st_q.lim == '0) begin
                st_d.cnt = '0;
            end else if (inc_w >= {1'b0, st_q.lim}) begin
                st_d.cnt = '0;
                st_d.ovf = ~st_q.ovf;
            end else begin
                st_d.cnt = inc_w[CNT_W-1:0];
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q.cnt <= '0;
            st_q.lim <= '0;
            st_q.ovf <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o = st_q.cnt;
    assign lim_o   = st_q.lim;
    assign ovf_o   = st_q.ovf;

endmodule

// File: rtl/ctr_delayed_wrap.sv
module ctr_delayed_wrap #(
    parameter int unsigned CNT_W     = 16,
    parameter int unsigned DELAY_CYC = 2
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             start_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic [CNT_W-1:0] count_o,
    output logic             ovf_o
);

    logic             rise_w;
    logic             step_w;
    logic [CNT_W-1:0] lim_w;

    ctr_edge_detect i_edge (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .start_i (start_i),
        .rise_o  (rise_w)
    );

    ctr_start_delay #(.DELAY_CYC(DELAY_CYC)) i_delay (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .start_i (start_i),
        .rise_i  (rise_w),
        .step_o  (step_w)
    );

    ctr_wrap_core #(.CNT_W(CNT_W)) i_core (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .rise_i  (rise_w),
        .step_i  (step_w),
        .limit_i (limit_i),
        .count_o (count_o),
        .lim_o   (lim_w),
        .ovf_o   (ovf_o)
    );

endmodule

// File: rtl/ctr_delayed_wrap_chk.sv
module ctr_delayed_wrap_chk #(
    parameter int unsigned CNT_W = 16
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic             start_i,
    input logic [CNT_W-1:0] count_o,
    input logic             ovf_o,
    input logic             rise,
    input logic             step,
    input logic [CNT_W-1:0] lim
);

    // R2: the rise edge clears the count
    a_r2_rise_clears: assert property (@(posedge clk_i) disable iff (rst_i)
        rise |=> (count_o == '0));

    // R3: start high without a counting step leaves the count untouched
    a_r3_hold_in_wait: assert property (@(posedge clk_i) disable iff (rst_i)
        (start_i && !rise && !step) |=> $stable(count_o));

    // R4: the count advances by one below the terminal value
    a_r4_increment: assert property (@(posedge clk_i) disable iff (rst_i)
        (step && ({1'b0, count_o} + 1'b1 < {1'b0, lim}))
        |=> ({1'b0, count_o} == {1'b0, $past(count_o)} + 1'b1));

    // R4: the count never reaches a terminal value of two or more
    a_r4_in_range: assert property (@(posedge clk_i) disable iff (rst_i)
        (!rise && lim > 1) |-> (count_o < lim));

    // R5: the flag inverts exactly when a step wraps to zero
    a_r5_toggle_on_wrap: assert property (@(posedge clk_i) disable iff (rst_i)
        step |=> ((ovf_o != $past(ovf_o)) == ((count_o == '0) && (lim != '0))));

    // R5: the flag holds without a step
    a_r5_hold_flag: assert property (@(posedge clk_i) disable iff (rst_i)
        !step |=> $stable(ovf_o));

    // R7: the latched terminal value changes only on a rise
    a_r7_limit_held: assert property (@(posedge clk_i) disable iff (rst_i)
        !rise |=> $stable(lim));

    // R8: start low freezes count and flag
    a_r8_freeze: assert property (@(posedge clk_i) disable iff (rst_i)
        !start_i |=> ($stable(count_o) && $stable(ovf_o)));

endmodule

bind ctr_delayed_wrap ctr_delayed_wrap_chk #(.CNT_W(CNT_W)) i_chk (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .start_i (start_i),
    .count_o (count_o),
    .ovf_o   (ovf_o),
    .rise    (rise_w),
    .step    (step_w),
    .lim     (lim_w)
);

// File: tb/test_ctr_delayed_wrap.sv
module test_ctr_delayed_wrap;

    localparam int PERIOD = 10;
    localparam int W      = 16;
    localparam int DLY    = 2;

    typedef struct {
        logic [W-1:0] cnt;
        logic         ovf;
        string        tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [W-1:0] limit = '0;
    logic [W-1:0] count;
    logic         ovf;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    exp_t sb_q[$];

    // reference model state
    logic [W-1:0] m_cnt = '0;
    logic [W-1:0] m_lim = '0;
    logic         m_ovf = 1'b0;
    logic         m_sq  = 1'b0;
    bit           m_run = 1'b0;
    int           m_dly = 0;

    always #(PERIOD/2) clk = ~clk;

    ctr_delayed_wrap #(.CNT_W(W), .DELAY_CYC(DLY)) i_ctr_delayed_wrap (
        .clk_i   (clk),
        .rst_i   (rst),
        .start_i (start),
        .limit_i (limit),
        .count_o (count),
        .ovf_o   (ovf)
    );

    task automatic check(input string tag, input logic [W-1:0] c, input logic o,
                         input logic [W-1:0] ec, input logic eo);
        total++;
        if (c !== ec || o !== eo) begin
            bad++;
            $display("FAIL %s: count=%0d ovf=%0b expected count=%0d ovf=%0b",
                     tag, c, o, ec, eo);
        end
    endtask

    // driver: apply inputs for one edge and push the predicted result
    task automatic drive(input logic s, input logic [W-1:0] v, input string tag);
        exp_t e;
        @(negedge clk);
        start = s;
        limit = v;
        if (s && !m_sq) begin
            m_cnt = '0; m_lim = v; m_dly = DLY; m_run = 1'b1;
        end else if (!s) begin
            m_run = 1'b0;
        end else if (m_run && m_dly > 0) begin
            m_dly--;
        end else if (m_run && m_lim != '0) begin
            if (int'(m_cnt) + 1 >= int'(m_lim)) begin
                m_cnt = '0; m_ovf = ~m_ovf;
            end else begin
                m_cnt = m_cnt + 1'b1;
            end
        end
        m_sq  = s;
        e.cnt = m_cnt;
        e.ovf = m_ovf;
        e.tag = tag;
        sb_q.push_back(e);
    endtask

    // monitor: compare after each edge
    initial begin
        forever begin
            @(posedge clk);
            #(PERIOD/4);
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                check(e.tag, count, ovf, e.cnt, e.ovf);
            end
        end
    end

    initial begin
        #(PERIOD * 20000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: count=%0d ovf=%0b expected run to end", count, ovf);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        start = 1'b1;
        limit = 16'd9;
        repeat (3) @(negedge clk);
        check("R1", count, ovf, '0, 1'b0);
        start = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        check("R1", count, ovf, '0, 1'b0);

        // R2, R3, R6: terminal value 5, first toggle on 7th edge
        for (int i = 0; i < 18; i++)
            drive(1'b1, 16'd5, (i == 0) ? "R2" : (i <= DLY) ? "R3" : (i <= 7) ? "R6" : "R5");

        // R7: the limit input moves during the run, sequence keeps modulo 5
        for (int i = 0; i < 9; i++)
            drive(1'b1, 16'(2 + i), "R7");

        // R4/R5 with start dropping on the edge where a wrap is due (R8)
        while (!(m_run && m_dly == 0 && int'(m_cnt) + 1 == int'(m_lim)))
            drive(1'b1, 16'd5, "R4");
        for (int i = 0; i < 4; i++)
            drive(1'b0, 16'd7, "R8");

        // R9: new run with value 3 and a fresh wait
        for (int i = 0; i < 11; i++)
            drive(1'b1, 16'd3, (i <= DLY) ? "R9" : "R4");
        drive(1'b0, 16'd3, "R8");

        // R10: terminal value 0, then 1
        for (int i = 0; i < 7; i++)
            drive(1'b1, 16'd0, "R10");
        drive(1'b0, 16'd1, "R8");
        for (int i = 0; i < 7; i++)
            drive(1'b1, 16'd1, "R10");
        drive(1'b0, 16'd1, "R8");

        // R4: large terminal value, plain increments
        for (int i = 0; i < 12; i++)
            drive(1'b1, 16'hFFFF, "R4");

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule